// File: doc/BRIEF.md
# Camera-Control Two-Wire Register Master

This block is a single-master controller for a two-wire, open-drain serial bus. It carries out register-access transactions against a camera-sensor slave. A command port takes an operation code, a 7-bit slave address, an 8-bit register index and a byte count. The controller then sequences the whole transaction on the bus by itself: START, the address byte, the index byte, data bytes, a repeated START where one is needed, acknowledge handling and STOP. Read bytes come back on a valid strobe. Write bytes are pulled from the host with a take strobe. A single done pulse reports success or a missing acknowledge.

A random-location read sends the index as a dummy write first. It then issues a repeated START and addresses the slave again with the read bit set. A current-location read goes straight to the read-addressed phase and uses the slave's own auto-incremented pointer. Both kinds of read, and writes, can be single or sequential. The serial clock comes from a programmable divider of the system clock. The controller only pulls the lines low and never drives them high. Bus arbitration and clock stretching by the slave are not handled.

Top module: `cci_master`

## Requirements
- R1: After reset and between transactions, `cmd_ready` is 1, `done` is 0 and both `scl_oe` and `sda_oe` are 0, so the bus is released.
- R2: The first byte after any START is the 7-bit address followed by the direction bit (0 = write, 1 = read). Every byte goes out MSB first. The controller releases SDA in the ninth clock so the slave can acknowledge.
- R3: `cmd_op` = 0 (write) produces START, address+W, index, `cmd_cnt`+1 data bytes, STOP. `wr_take` pulses once per data byte, at the cycle in which `wr_data` is captured.
- R4: `cmd_op` = 1 (random read) produces START, address+W, index, repeated START, address+R, then `cmd_cnt`+1 read bytes and STOP.
- R5: `cmd_op` = 2 or 3 (current read) produces START, address+R, then `cmd_cnt`+1 read bytes and STOP, with no index byte.
- R6: Each read byte appears on `rd_data` with a one-cycle `rd_valid`. The controller drives ACK (SDA low) after every read byte except the last, and NACK (SDA released) after the last.
- R7: A NACK on any byte the controller sends (address, index or write data) ends the transaction at once with STOP, and `done` comes with `err` = 1. No further byte is sent and no further `wr_take` is given.
- R8: SDA changes only while SCL is low, except for the START (SDA falls with SCL high) and STOP (SDA rises with SCL high) conditions. SCL and SDA never change in the same clock cycle.
- R9: Within a byte, the SCL period is 4*(max(`div_q`,2)+1) system clocks.
- R10: `done` is a single-cycle pulse that follows STOP completion. `err` = 0 after a fully acknowledged transaction, and `cmd_ready` is 1 again in the same cycle.
- R11: `cmd_valid` is ignored while a transaction is in progress (`cmd_ready` = 0); no second transaction starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_q | input | DIV_W | Quarter-bit divider; each SCL quarter lasts max(div_q,2)+1 clocks |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | 0 write, 1 random read, 2/3 current read |
| cmd_addr | input | 7 | Slave address |
| cmd_index | input | 8 | Register index (random operations) |
| cmd_cnt | input | CNT_W | Number of data bytes minus one |
| cmd_ready | output | 1 | Idle; command accepted when high together with cmd_valid |
| wr_data | input | 8 | Next write data byte, captured when wr_take rises |
| wr_take | output | 1 | Pulse: wr_data captured |
| rd_data | output | 8 | Received byte |
| rd_valid | output | 1 | Pulse: rd_data holds a new byte |
| done | output | 1 | Pulse: transaction finished |
| err | output | 1 | Status of the last transaction, 1 = missing acknowledge |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_i | input | 1 | Sampled SDA line level |

## Verification
The assertions assume that `div_q` stays constant while a transaction runs. They also assume that the slave changes SDA only while SCL is low and never holds SCL low. The bench sets the divider only while the controller is idle. Its slave model drives SDA on falling SCL edges and never touches SCL. The bench applies `wr_data` from a buffer indexed by the number of `wr_take` pulses seen so far, so a valid byte is always present at the capture cycle.

// File: rtl/cci_pkg.sv
package cci_pkg;
  localparam logic [1:0] OP_WRITE   = 2'd0;
  localparam logic [1:0] OP_RD_RAND = 2'd1;

  typedef enum logic [2:0] {BK_START, BK_RSTART, BK_STOP, BK_WR, BK_RD} bk_e;

  // Line pull per quarter phase: {scl_low, sda_low}
  function automatic logic [1:0] bus_drive(bk_e k, logic [1:0] ph, logic b);
    logic [1:0] r;
    r = 2'b00;
    case (k)
      BK_START:  r = (ph == 2'd0) ? 2'b00 : (ph == 2'd3) ? 2'b11 : 2'b01;
      BK_RSTART: r = (ph == 2'd0) ? 2'b10 : (ph == 2'd1) ? 2'b00 :
                     (ph == 2'd2) ? 2'b01 : 2'b11;
      BK_STOP:   r = (ph == 2'd0) ? 2'b11 : (ph == 2'd1) ? 2'b01 : 2'b00;
      BK_WR:     r = {(ph == 2'd0 || ph == 2'd3), ~b};
      BK_RD:     r = {(ph == 2'd0 || ph == 2'd3), 1'b0};
      default:   r = 2'b00;
    endcase
    return r;
  endfunction

  function automatic logic [7:0] addr_byte(logic [6:0] a, logic rd);
    return {a, rd};
  endfunction

  function automatic logic is_cur_read(logic [1:0] op);
    return (op != OP_WRITE) && (op != OP_RD_RAND);
  endfunction
endpackage

// File: rtl/cci_tick_gen.sv
module cci_tick_gen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_q,
  output logic             tick
);
  logic [DIV_W-1:0] cnt, lim;

  assign lim  = (div_q < DIV_W'(2)) ? DIV_W'(2) : div_q;
  assign tick = (cnt >= lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= tick ? '0 : cnt + 1'b1;
  end

  // R9
  tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/cci_bit_engine.sv
module cci_bit_engine
  import cci_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic go,
  input  bk_e  go_kind,
  input  logic go_bit,
  input  logic sda_i,
  output logic busy,
  output logic done,
  output logic rbit,
  output logic scl_oe,
  output logic sda_oe
);
  bk_e        kind;
  logic       wbit;
  logic [1:0] ph;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; rbit <= 1'b0;
      scl_oe <= 1'b0; sda_oe <= 1'b0;
      kind <= BK_STOP; wbit <= 1'b0; ph <= 2'd0;
    end else begin
      done <= 1'b0;
      if (go) begin
        busy <= 1'b1; kind <= go_kind; wbit <= go_bit; ph <= 2'd0;
      end else if (busy && tick) begin
        {scl_oe, sda_oe} <= bus_drive(kind, ph, wbit);
        ph <= ph + 2'd1;
        if (ph == 2'd3) begin
          busy <= 1'b0; done <= 1'b1; rbit <= sda_i;
        end
      end
    end
  end

  // R11
  go_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> !busy);
  // R8
  edge_sep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!$stable(scl_oe) && !$stable(sda_oe)));
  // R8
  sda_hi_chg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !scl_oe && !$past(scl_oe))
      |-> (kind == BK_START || kind == BK_RSTART || kind == BK_STOP));
endmodule

// File: rtl/cci_master.sv
module cci_master
  import cci_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div_q,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [6:0]       cmd_addr,
  input  logic [7:0]       cmd_index,
  input  logic [CNT_W-1:0] cmd_cnt,
  output logic             cmd_ready,
  input  logic [7:0]       wr_data,
  output logic             wr_take,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             done,
  output logic             err,
  output logic             scl_oe,
  output logic             sda_oe,
  input  logic             sda_i
);
  typedef enum logic [2:0] {S_IDLE, S_START, S_TX, S_RS, S_RX, S_STOP} st_e;
  typedef enum logic [1:0] {T_ADDR, T_IDX, T_DATA, T_RADDR} tx_e;

  st_e              state;
  tx_e              txsel;
  logic [1:0]       op_q;
  logic [6:0]       addr_q;
  logic [7:0]       idx_q, shreg;
  logic [CNT_W-1:0] remain;
  logic [3:0]       bitn;
  logic             fail_q, go_q, gb_q;
  bk_e              gk_q;
  logic             tick, eng_busy, eng_done, eng_rbit;

  cci_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .div_q(div_q), .tick(tick));

  cci_bit_engine u_eng (
    .clk(clk), .rst_n(rst_n), .tick(tick), .go(go_q), .go_kind(gk_q),
    .go_bit(gb_q), .sda_i(sda_i), .busy(eng_busy), .done(eng_done),
    .rbit(eng_rbit), .scl_oe(scl_oe), .sda_oe(sda_oe));

  assign cmd_ready = (state == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE; txsel <= T_ADDR; op_q <= OP_WRITE; addr_q <= '0;
      idx_q <= '0; shreg <= '0; remain <= '0; bitn <= '0; fail_q <= 1'b0;
      go_q <= 1'b0; gb_q <= 1'b0; gk_q <= BK_STOP;
      wr_take <= 1'b0; rd_data <= '0; rd_valid <= 1'b0; done <= 1'b0; err <= 1'b0;
    end else begin
      go_q <= 1'b0; wr_take <= 1'b0; rd_valid <= 1'b0; done <= 1'b0;
      case (state)
        S_IDLE: if (cmd_valid) begin
          op_q <= cmd_op; addr_q <= cmd_addr; idx_q <= cmd_index;
          remain <= cmd_cnt; fail_q <= 1'b0;
          state <= S_START; go_q <= 1'b1; gk_q <= BK_START;
        end
        S_START: if (eng_done) begin
          shreg <= addr_byte(addr_q, is_cur_read(op_q));
          txsel <= T_ADDR; bitn <= '0; state <= S_TX;
          go_q <= 1'b1; gk_q <= BK_WR; gb_q <= addr_q[6];
        end
        S_TX: if (eng_done) begin
          if (bitn < 4'd7) begin
            bitn <= bitn + 4'd1; shreg <= shreg << 1;
            go_q <= 1'b1; gk_q <= BK_WR; gb_q <= shreg[6];
          end else if (bitn == 4'd7) begin
            bitn <= 4'd8; go_q <= 1'b1; gk_q <= BK_RD;
          end else if (eng_rbit) begin
            fail_q <= 1'b1; state <= S_STOP; go_q <= 1'b1; gk_q <= BK_STOP;
          end else begin
            bitn <= '0; go_q <= 1'b1;
            case (txsel)
              T_ADDR, T_RADDR:
                if (txsel == T_RADDR || is_cur_read(op_q)) begin
                  state <= S_RX; gk_q <= BK_RD;
                end else begin
                  shreg <= idx_q; txsel <= T_IDX; gk_q <= BK_WR; gb_q <= idx_q[7];
                end
              T_IDX:
                if (op_q == OP_WRITE) begin
                  shreg <= wr_data; wr_take <= 1'b1; txsel <= T_DATA;
                  gk_q <= BK_WR; gb_q <= wr_data[7];
                end else begin
                  state <= S_RS; gk_q <= BK_RSTART;
                end
              default:
                if (remain == '0) begin
                  state <= S_STOP; gk_q <= BK_STOP;
                end else begin
                  remain <= remain - 1'b1; shreg <= wr_data; wr_take <= 1'b1;
                  gk_q <= BK_WR; gb_q <= wr_data[7];
                end
            endcase
          end
        end
        S_RS: if (eng_done) begin
          shreg <= addr_byte(addr_q, 1'b1); txsel <= T_RADDR; bitn <= '0;
          state <= S_TX; go_q <= 1'b1; gk_q <= BK_WR; gb_q <= addr_q[6];
        end
        S_RX: if (eng_done) begin
          go_q <= 1'b1;
          if (bitn < 4'd7) begin
            shreg <= {shreg[6:0], eng_rbit}; bitn <= bitn + 4'd1; gk_q <= BK_RD;
          end else if (bitn == 4'd7) begin
            rd_data <= {shreg[6:0], eng_rbit}; rd_valid <= 1'b1;
            bitn <= 4'd8; gk_q <= BK_WR; gb_q <= (remain == '0);
          end else if (remain == '0) begin
            state <= S_STOP; gk_q <= BK_STOP;
          end else begin
            remain <= remain - 1'b1; bitn <= '0; gk_q <= BK_RD;
          end
        end
        S_STOP: if (eng_done) begin
          state <= S_IDLE; done <= 1'b1; err <= fail_q;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R1
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!scl_oe && !sda_oe && !eng_busy));
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R3
  no_rd_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_q == OP_WRITE) |-> !rd_valid);
  // R6
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && wr_take));
  // R7
  no_take_after_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail_q |-> !wr_take);
endmodule

// File: tb/tb_cci_master.sv
module tb_cci_master;
  localparam logic [6:0] SLV = 7'h36;

  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic [7:0] div_q = 8'd2;
  logic cmd_valid = 0; logic [1:0] cmd_op = 0; logic [6:0] cmd_addr = SLV;
  logic [7:0] cmd_index = 0; logic [3:0] cmd_cnt = 0;
  logic cmd_ready, wr_take, rd_valid, done, err, scl_oe, sda_oe;
  logic [7:0] wr_data, rd_data;
  logic s_drv = 0;
  wire scl = ~scl_oe;
  wire sda = ~(sda_oe | s_drv);

  logic [7:0] wbuf[16];
  int take_n = 0;
  assign wr_data = wbuf[take_n[3:0]];

  cci_master dut (.clk(clk), .rst_n(rst_n), .div_q(div_q), .cmd_valid(cmd_valid),
    .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_index(cmd_index), .cmd_cnt(cmd_cnt),
    .cmd_ready(cmd_ready), .wr_data(wr_data), .wr_take(wr_take), .rd_data(rd_data),
    .rd_valid(rd_valid), .done(done), .err(err), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .sda_i(sda));

  int n_chk = 0, n_bad = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---- slave model and bus monitors ----
  logic [7:0] mem[256], exp_mem[256];
  logic [7:0] rx_log[32], rd_log[32], ptr, sh;
  logic mack_log[32];
  int rx_n, rd_n, mack_n, starts, stops, rs_n, both_chg, rise_n, nack_at, mode, bitcnt;
  int cyc = 0, rise_t[3];
  bit pscl = 1, psda = 1, in_txn, exp_addr, got_idx, acked, to_tx, mack;

  always @(posedge clk) begin
    cyc++;
    if (wr_take) take_n++;
  end
  always @(negedge clk) if (rd_valid) begin rd_log[rd_n[4:0]] = rd_data; rd_n++; end

  always @(negedge clk) if (rst_n) begin
    if (scl != pscl && sda != psda) both_chg++;
    if (scl && pscl && psda && !sda) begin
      starts++; if (in_txn) rs_n++;
      in_txn = 1; mode = 1; bitcnt = 0; exp_addr = 1; got_idx = 0; s_drv = 0;
    end else if (scl && pscl && !psda && sda) begin
      stops++; in_txn = 0; mode = 0; s_drv = 0;
    end else if (scl && !pscl) begin
      if (rise_n < 3) begin rise_t[rise_n] = cyc; rise_n++; end
      if (mode == 1 && bitcnt < 8) begin sh = {sh[6:0], sda}; bitcnt++; end
      else if (mode == 2) begin
        if (bitcnt < 8) bitcnt++;
        else if (bitcnt == 8) begin mack = sda; mack_log[mack_n[4:0]] = sda; mack_n++; bitcnt = 9; end
      end
    end else if (!scl && pscl) begin
      if (mode == 1) begin
        if (bitcnt == 8) begin
          rx_log[rx_n[4:0]] = sh; acked = (rx_n != nack_at); to_tx = 0;
          if (exp_addr) begin acked = acked && (sh[7:1] == SLV); to_tx = acked && sh[0]; exp_addr = 0; end
          else if (!got_idx) begin if (acked) begin ptr = sh; got_idx = 1; end end
          else if (acked) begin mem[ptr] = sh; ptr++; end
          rx_n++; s_drv = acked; bitcnt = 9;
        end else if (bitcnt == 9) begin
          bitcnt = 0; s_drv = 0;
          if (!acked) mode = 0;
          else if (to_tx) begin mode = 2; s_drv = !mem[ptr][7]; end
        end
      end else if (mode == 2) begin
        if (bitcnt < 8) s_drv = !mem[ptr][3'(7 - bitcnt)];
        else if (bitcnt == 8) s_drv = 0;
        else begin
          ptr++; bitcnt = 0;
          if (!mack) s_drv = !mem[ptr][7]; else begin s_drv = 0; mode = 0; end
        end
      end
    end
    pscl = scl; psda = sda;
  end

  function automatic logic [7:0] wdat(int v, int k);
    return 8'(8'h3C + v * 16 + k * 7);
  endfunction

  function automatic int scl_per(int d);
    return 4 * (((d < 2) ? 2 : d) + 1);
  endfunction

  int got_err;
  task automatic run_cmd(input logic [1:0] op, input logic [6:0] a, input logic [7:0] ix,
                         input logic [3:0] c, input logic [7:0] d);
    rx_n = 0; rd_n = 0; mack_n = 0; starts = 0; stops = 0; rs_n = 0; rise_n = 0; take_n = 0;
    @(negedge clk);
    div_q = d; cmd_op = op; cmd_addr = a; cmd_index = ix; cmd_cnt = c; cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0;
    for (int t = 0; t < 20000 && !done; t++) @(negedge clk);
    chk(done == 1, "R10 done seen", done, 1);
    got_err = err;
    chk(cmd_ready == 1, "R10 ready with done", cmd_ready, 1);
    @(negedge clk);
    chk(done == 0, "R10 done single cycle", done, 0);
    repeat (4) @(negedge clk);
  endtask

  typedef struct packed { logic [1:0] op; logic [7:0] idx; logic [3:0] cnt; logic [7:0] div; } vec_t;
  localparam vec_t VT[8] = '{
    '{2'd0, 8'h10, 4'd0, 8'd2}, '{2'd0, 8'h20, 4'd3, 8'd3},
    '{2'd1, 8'h20, 4'd3, 8'd2}, '{2'd1, 8'h10, 4'd0, 8'd4},
    '{2'd2, 8'h00, 4'd0, 8'd0}, '{2'd3, 8'h00, 4'd2, 8'd5},
    '{2'd0, 8'hFE, 4'd2, 8'd2}, '{2'd1, 8'hFF, 4'd1, 8'd2}};

  initial begin
    #(20 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] pexp;
    int nb;
    for (int i = 0; i < 256; i++) begin mem[i] = 8'(i ^ 8'h5A); exp_mem[i] = 8'(i ^ 8'h5A); end
    nack_at = -1; ptr = 0; pexp = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(cmd_ready && !done && !scl_oe && !sda_oe, "R1 reset idle",
        {cmd_ready, done, scl_oe, sda_oe}, 4'b1000);
    rst_n = 1;
    repeat (3) @(negedge clk);

    for (int v = 0; v < 8; v++) begin
      nb = VT[v].cnt + 1;
      for (int k = 0; k < 16; k++) wbuf[k] = wdat(v, k);
      run_cmd(VT[v].op, SLV, VT[v].idx, VT[v].cnt, VT[v].div);
      chk(got_err == 0, "R10 err clear", got_err, 0);
      chk(stops == 1, "R3 one stop", stops, 1);
      chk(rise_t[2] - rise_t[1] == scl_per(VT[v].div), "R9 scl period",
          rise_t[2] - rise_t[1], scl_per(VT[v].div));
      if (VT[v].op == 2'd0) begin
        chk(rx_n == nb + 2 && rx_log[0] == {SLV, 1'b0} && rx_log[1] == VT[v].idx,
            "R2 write header", rx_n, nb + 2);
        chk(take_n == nb, "R3 take count", take_n, nb);
        for (int k = 0; k < nb; k++) begin
          chk(rx_log[k + 2] == wdat(v, k), "R3 write byte", rx_log[k + 2], wdat(v, k));
          exp_mem[8'(VT[v].idx + k)] = wdat(v, k);
        end
        chk(starts == 1 && rs_n == 0, "R3 single start", starts, 1);
        pexp = 8'(VT[v].idx + nb);
      end else begin
        if (VT[v].op == 2'd1) begin
          chk(rx_n == 3 && rx_log[0] == {SLV, 1'b0} && rx_log[1] == VT[v].idx
              && rx_log[2] == {SLV, 1'b1}, "R4 random read header", rx_n, 3);
          chk(starts == 2 && rs_n == 1, "R4 repeated start", starts, 2);
          pexp = VT[v].idx;
        end else begin
          chk(rx_n == 1 && rx_log[0] == {SLV, 1'b1}, "R5 current read header", rx_log[0], {SLV, 1'b1});
          chk(starts == 1 && rs_n == 0, "R5 no repeated start", starts, 1);
        end
        chk(rd_n == nb, "R6 read count", rd_n, nb);
        for (int k = 0; k < nb; k++) begin
          chk(rd_log[k] == exp_mem[8'(pexp + k)], "R6 read data", rd_log[k], exp_mem[8'(pexp + k)]);
          chk(mack_log[k] == (k == nb - 1), "R6 master ack/nack", mack_log[k], (k == nb - 1));
        end
        pexp = 8'(pexp + nb);
      end
    end

    // R7 wrong address: NACK on address
    run_cmd(2'd0, 7'h21, 8'h80, 4'd2, 8'd2);
    chk(got_err == 1 && rx_n == 1 && stops == 1, "R7 address nack", {got_err, rx_n}, 9'h101);
    chk(take_n == 0, "R7 no take after address nack", take_n, 0);
    // R7 NACK on index in random read: no repeated start, no data
    nack_at = 1;
    run_cmd(2'd1, SLV, 8'h80, 4'd1, 8'd2);
    chk(got_err == 1 && rx_n == 2 && starts == 1 && rd_n == 0, "R7 index nack",
        {got_err, rx_n}, 9'h102);
    // R7 NACK on second data byte of a write
    nack_at = 3;
    run_cmd(2'd0, SLV, 8'h80, 4'd3, 8'd2);
    chk(got_err == 1 && rx_n == 4, "R7 data nack", {got_err, rx_n}, 9'h104);
    chk(take_n == 2, "R7 takes stop at nack", take_n, 2);
    nack_at = -1;

    // R11 command ignored while busy
    rx_n = 0; starts = 0; stops = 0; take_n = 0;
    @(negedge clk);
    div_q = 8'd2; cmd_op = 2'd0; cmd_addr = SLV; cmd_index = 8'h90; cmd_cnt = 4'd0; cmd_valid = 1;
    @(negedge clk);
    cmd_op = 2'd2;
    repeat (60) @(negedge clk);
    chk(cmd_ready == 0, "R11 busy not ready", cmd_ready, 0);
    cmd_valid = 0;
    for (int t = 0; t < 20000 && !done; t++) @(negedge clk);
    repeat (100) @(negedge clk);
    chk(starts == 1 && stops == 1 && rx_n == 3, "R11 no extra transaction", starts, 1);

    // R8 and R1 after all traffic
    chk(both_chg == 0, "R8 scl/sda never change together", both_chg, 0);
    chk(cmd_ready && !scl_oe && !sda_oe, "R1 idle after traffic", {cmd_ready, scl_oe, sda_oe}, 3'b100);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule